// File: doc/BRIEF.md
# Two-Channel Wiper Register Slave on a Two-Wire Serial Bus

This block is the digital front end of a two-channel, 8-bit digitally controlled resistor. It watches the two bus lines (clock and data) of an I2C-compatible bus using a fast local clock, and recognises the start and stop conditions. It answers one 7-bit bus address and returns an acknowledge. The bus master then either writes an instruction byte followed by wiper codes, or reads back the stored code of the channel that the last instruction selected. The block drives the shared data line only by pulling it low through an output enable, which makes an open-drain output.

The instruction byte selects a channel and sets or clears that channel's shutdown flag. While a channel is shut down, its effective output code is forced to zero and its A-terminal-open signal is raised. The stored code is kept intact and can still be rewritten. The address is either fixed or taken partly from two strap pins, and a parameter selects which. The bus side has no stream interface and applies no back-pressure: the master sets the pace, and the block neither stretches the clock nor holds off a transfer. The local clock must run at least 20 times faster than the bus clock.

Top module: `tw_dual_wiper`

## Requirements
- R1: After reset both stored codes are 0x80, both shutdown flags are clear, both outputs read 0x80 and the data-line enable is low.
- R2: When the first seven bits after a START equal the block's address, the block pulls the data line low during the ninth clock pulse. When they differ, the block never drives the data line until the next START.
- R3: In the instruction byte (the second byte of a write), bit 7 selects the channel (0 for the first, 1 for the second) and bit 6 is that channel's shutdown flag. Bits 5 to 0 have no effect.
- R4: Every complete data byte that follows the instruction in the same write loads the selected channel's stored code, and each byte is acknowledged. Codes change only in the local clock cycle after a bus clock rise is seen.
- R5: While a channel's shutdown flag is set, its output is 0x00 and its open flag is high. Writes still update its stored code, and clearing the flag shows the current stored code.
- R6: In a read, the stored code of the channel named by the most recent instruction byte (with or without a data byte after it) is sent MSB first, starting right after the address acknowledge. The byte repeats while the master acknowledges, and after a master NACK the data line is left released.
- R7: A START or STOP in the middle of a byte aborts the transfer. The partial byte changes no stored code, and the data-line enable is low on the next cycle.
- R8: A START is the data line falling while the clock is high, and a STOP is the data line rising while the clock is high. Bits sent after a STOP without a new START are ignored. The data-line enable changes only while the sampled bus clock is low, apart from an abort.
- R9: In the pin-configured variant the address is 01011 followed by the two strap pins (upper pin first). In the fixed variant it is 0101111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | 2 | Strap pins for the two low address bits (pin-configured variant) |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| wiper_o | output | NCH x 8 | Effective code per channel, zero while shut down |
| open_a_o | output | NCH | Per-channel shutdown / A-terminal-open flag |

## Verification
The bench builds the pin-configured variant with two channels and drives the strap pins to 10 and then to 11. Both address values are therefore matched, and 0101111 is rejected while the pins read 10. With this choice the strap decode and the address-mismatch path are both exercised in one build. The fixed-address branch of the decoder is left to a separate build. Two channels put bit 7 of the instruction in the channel-select role and bit 6 in the shutdown role. This lets the bench check that the pointer steers reads to either channel, and that the ignored low bits leave both untouched.

// File: rtl/tw_wiper_pkg.sv
package tw_wiper_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_ACK,
    LS_TX,
    LS_RACK,
    LS_SKIP
  } link_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_INSTR,
    BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_d,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data moves while clock is steadily high: framing condition
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tw_addr_match.sv
module tw_addr_match #(
  parameter bit         USE_PINS   = 1'b1,
  parameter logic [6:0] FIXED_ADDR = 7'b0101111,
  parameter logic [4:0] PIN_PREFIX = 5'b01011
) (
  input  logic [1:0] addr_pins_i,
  output logic [6:0] my_addr
);
  generate
    if (USE_PINS) begin : g_pins
      assign my_addr = {PIN_PREFIX, addr_pins_i};
    end else begin : g_fixed
      logic [1:0] unused_pins;
      assign unused_pins = addr_pins_i;
      assign my_addr     = FIXED_ADDR;
    end
  endgenerate
endmodule

// File: rtl/tw_link_ctrl.sv
module tw_link_ctrl
  import tw_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic [6:0]        my_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              load_instr,
  output logic              load_data,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CNT_W = $clog2(BYTE_W);

  link_state_t       st;
  byte_kind_t        kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              ack_hi;
  logic              rw;
  logic              last_bit;

  assign rx_byte    = {sh[BYTE_W-2:0], sda_s};
  assign last_bit   = (st == LS_RX) && scl_rise && (cnt == CNT_W'(BYTE_W - 1));
  assign load_instr = last_bit && (kind == BK_INSTR);
  assign load_data  = last_bit && (kind == BK_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LS_IDLE;
      kind   <= BK_ADDR;
      cnt    <= '0;
      sh     <= '0;
      ack_hi <= 1'b0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      st     <= LS_RX;
      kind   <= BK_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      st     <= LS_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        LS_RX: begin
          if (scl_rise) begin
            sh <= rx_byte;
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              cnt    <= '0;
              ack_hi <= 1'b0;
              if (kind != BK_ADDR) begin
                st <= LS_ACK;
              end else if (sh[6:0] == my_addr) begin
                st <= LS_ACK;
                rw <= sda_s;
              end else begin
                st <= LS_SKIP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        LS_ACK: begin
          if (scl_rise) ack_hi <= 1'b1;
          if (scl_fall) begin
            if (!ack_hi) begin
              sda_oe <= 1'b1;
            end else if (kind == BK_ADDR && rw) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              cnt    <= '0;
              st     <= LS_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= LS_RX;
              kind   <= (kind == BK_ADDR) ? BK_INSTR : BK_DATA;
            end
          end
        end
        LS_TX: begin
          if (scl_rise) begin
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              cnt    <= '0;
              ack_hi <= 1'b0;
              st     <= LS_RACK;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          if (scl_fall && cnt != '0) begin
            sh     <= {sh[BYTE_W-2:0], 1'b0};
            sda_oe <= ~sh[BYTE_W-2];
          end
        end
        LS_RACK: begin
          if (scl_fall) begin
            if (ack_hi) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              cnt    <= '0;
              st     <= LS_TX;
            end else begin
              sda_oe <= 1'b0;
            end
          end
          if (scl_rise) begin
            if (!sda_s) ack_hi <= 1'b1;
            else        st     <= LS_SKIP;
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tw_wiper_bank.sv
module tw_wiper_bank
  import tw_wiper_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_instr,
  input  logic                          load_data,
  input  logic [BYTE_W-1:0]             rx_byte,
  output logic [BYTE_W-1:0]             rd_data,
  output logic [NCH-1:0][BYTE_W-1:0]    wiper_o,
  output logic [NCH-1:0]                open_a_o
);
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SD_BIT = BYTE_W - 1 - CHW;
  localparam logic [BYTE_W-1:0] MID = BYTE_W'(1) << (BYTE_W - 1);

  logic [CHW-1:0]                   ptr;
  logic [CHW-1:0]                   sel;
  logic [NCH-1:0][BYTE_W-1:0]       code_q;
  logic [NCH-1:0]                   sd_q;

  assign sel = rx_byte[BYTE_W-1 -: CHW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (load_instr) ptr <= sel;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          code_q[i] <= MID;
          sd_q[i]   <= 1'b0;
        end else begin
          if (load_data && ptr == CHW'(i))  code_q[i] <= rx_byte;
          if (load_instr && sel == CHW'(i)) sd_q[i]   <= rx_byte[SD_BIT];
        end
      end
      assign wiper_o[i]  = sd_q[i] ? '0 : code_q[i];
      assign open_a_o[i] = sd_q[i];
    end
  endgenerate

  assign rd_data = code_q[ptr];
endmodule

// File: rtl/tw_dual_wiper.sv
module tw_dual_wiper
  import tw_wiper_pkg::*;
#(
  parameter int         NCH        = 2,
  parameter bit         USE_PINS   = 1'b1,
  parameter logic [6:0] FIXED_ADDR = 7'b0101111,
  parameter logic [4:0] PIN_PREFIX = 5'b01011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [1:0]                 addr_pins_i,
  output logic                       sda_oe_o,
  output logic [NCH-1:0][BYTE_W-1:0] wiper_o,
  output logic [NCH-1:0]             open_a_o
);
  logic scl_s, scl_d, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [6:0]        my_addr;
  logic [BYTE_W-1:0] rd_data;
  logic [BYTE_W-1:0] rx_byte;
  logic              load_instr, load_data;

  tw_line_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .scl_d(scl_d), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  tw_addr_match #(
    .USE_PINS(USE_PINS), .FIXED_ADDR(FIXED_ADDR), .PIN_PREFIX(PIN_PREFIX)
  ) u_adr (
    .addr_pins_i(addr_pins_i), .my_addr(my_addr)
  );

  tw_link_ctrl u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p),
    .my_addr(my_addr), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .load_instr(load_instr),
    .load_data(load_data), .rx_byte(rx_byte)
  );

  tw_wiper_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .load_instr(load_instr), .load_data(load_data), .rx_byte(rx_byte),
    .rd_data(rd_data), .wiper_o(wiper_o), .open_a_o(open_a_o)
  );
endmodule

// File: rtl/tw_wiper_chk.sv
module tw_wiper_chk #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_s,
  input logic                 scl_d,
  input logic                 start_p,
  input logic                 stop_p,
  input logic                 sda_oe_o,
  input logic [NCH-1:0][7:0]  wiper_o,
  input logic [NCH-1:0]       open_a_o
);
  // R8: output enable moves only after a low clock sample, unless framing aborts
  assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_oe_o != $past(sda_oe_o)) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_s));

  // R7: framing events release the line on the next cycle
  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |=> !sda_oe_o);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R4: codes move only right after a clock rise was sampled
      assert_load_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wiper_o[i] != $past(wiper_o[i])) |-> $past(scl_s && !scl_d));
      // R5: a shut-down channel shows code zero
      assert_shutdown_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        open_a_o[i] |-> (wiper_o[i] == 8'h00));
    end
  endgenerate
endmodule

bind tw_dual_wiper tw_wiper_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_d(scl_d),
  .start_p(start_p), .stop_p(stop_p), .sda_oe_o(sda_oe_o),
  .wiper_o(wiper_o), .open_a_o(open_a_o)
);

// File: tb/tw_dual_wiper_tb.sv
module tw_dual_wiper_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       scl, sda_m;
  logic [1:0] pins;
  logic       sda_oe;
  logic [1:0][7:0] wiper;
  logic [1:0] open_a;
  wire        sda_bus = sda_m & ~sda_oe;

  tw_dual_wiper #(.NCH(2), .USE_PINS(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_pins_i(pins), .sda_oe_o(sda_oe), .wiper_o(wiper), .open_a_o(open_a)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0] m_w [2];
  bit         m_sd [2];
  int         m_ptr = 0;
  int         settle = 0;
  bit         cmp_on = 1'b0;
  int         oe_hi = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of effective outputs (R4, R5)
  always @(negedge clk) begin
    if (sda_oe) oe_hi++;
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        for (int c = 0; c < 2; c++) begin
          check(wiper[c] == (m_sd[c] ? 8'h00 : m_w[c]), "R4/R5", "clocked wiper",
                wiper[c], m_sd[c] ? 0 : m_w[c]);
          check(open_a[c] == m_sd[c], "R5", "clocked open flag", open_a[c], m_sd[c]);
        end
      end
    end
  end

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic apply(input int act, input logic [7:0] b);
    if (act == 1) begin
      m_ptr = b[7];
      m_sd[b[7]] = b[6];
    end else if (act == 2) begin
      m_w[m_ptr] = b;
    end
    settle = 8;
  endtask

  task automatic do_start();
    sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0; hold();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold();
  endtask

  task automatic put_bits(input logic [7:0] b, input int nb, input int act);
    for (int i = 0; i < nb; i++) begin
      sda_m = b[7-i]; hold(); scl = 1'b1;
      if (i == 7) apply(act, b);
      hold(); hold(); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int act, output bit acked);
    put_bits(b, 8, act);
    sda_m = 1'b1; hold(); scl = 1'b1; hold();
    acked = (sda_bus == 1'b0);
    hold(); scl = 1'b0; hold();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 0; i < 8; i++) begin
      hold(); scl = 1'b1; hold(); b[7-i] = sda_bus; hold(); scl = 1'b0;
    end
    sda_m = !mack; hold(); scl = 1'b1; hold(); hold(); scl = 1'b0; hold(); sda_m = 1'b1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] ins,
                    input logic [7:0] dq[$], input bit exp_ack);
    bit ak;
    do_start();
    send_byte({a, 1'b0}, 0, ak);
    check(ak == exp_ack, "R2", "address ack", ak, exp_ack);
    send_byte(ins, exp_ack ? 1 : 0, ak);
    check(ak == exp_ack, "R3", "instruction ack", ak, exp_ack);
    foreach (dq[k]) begin
      send_byte(dq[k], exp_ack ? 2 : 0, ak);
      check(ak == exp_ack, "R4", "data ack", ak, exp_ack);
    end
    do_stop();
  endtask

  task automatic rd(input logic [6:0] a, input int nb);
    bit ak;
    logic [7:0] v;
    do_start();
    send_byte({a, 1'b1}, 0, ak);
    check(ak, "R6", "read address ack", ak, 1);
    for (int k = 0; k < nb; k++) begin
      recv_byte(v, k < nb - 1);
      check(v == m_w[m_ptr], "R6", "read byte", v, m_w[m_ptr]);
    end
    hold();
    check(!sda_oe, "R6", "line released after NACK", sda_oe, 0);
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] q0[$];
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; pins = 2'b10;
    m_w[0] = 8'h80; m_w[1] = 8'h80; m_sd[0] = 0; m_sd[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(wiper[0] == 8'h80 && wiper[1] == 8'h80, "R1", "reset codes", wiper, 16'h8080);
    check(open_a == 2'b00, "R1", "reset open flags", open_a, 0);
    check(!sda_oe, "R1", "reset line enable", sda_oe, 0);
    cmp_on = 1'b1;
    hold();

    // R4: load and reload channel 0, pin address 0101110 (R9)
    wr(7'h2E, 8'h00, '{8'h3C, 8'hC3}, 1'b1);
    check(wiper[0] == 8'hC3, "R4", "reload ch0", wiper[0], 8'hC3);
    wr(7'h2E, 8'h80, '{8'hA5}, 1'b1);
    check(wiper[1] == 8'hA5, "R4", "load ch1", wiper[1], 8'hA5);

    // R6: pointer steers reads, repeated bytes
    rd(7'h2E, 3);
    q0 = {};
    wr(7'h2E, 8'h00, q0, 1'b1);
    rd(7'h2E, 1);

    // R5: shutdown on ch1, write while shut down, read stored, release
    wr(7'h2E, 8'hC0, '{8'h11}, 1'b1);
    check(wiper[1] == 8'h00 && open_a[1], "R5", "shutdown output", wiper[1], 0);
    rd(7'h2E, 1);
    wr(7'h2E, 8'h80, q0, 1'b1);
    check(wiper[1] == 8'h11 && !open_a[1], "R5", "leave shutdown", wiper[1], 8'h11);

    // R3: low instruction bits ignored
    wr(7'h2E, 8'h3F, '{8'h5A}, 1'b1);
    check(wiper[0] == 8'h5A && open_a == 2'b00, "R3", "ignored low bits", wiper[0], 8'h5A);
    check(wiper[1] == 8'h11, "R3", "other channel untouched", wiper[1], 8'h11);

    // R4: boundary codes
    wr(7'h2E, 8'h00, '{8'h00, 8'hFF}, 1'b1);
    check(wiper[0] == 8'hFF, "R4", "full scale", wiper[0], 8'hFF);

    // R2: mismatched address, line never driven
    oe_hi = 0;
    wr(7'h2F, 8'h00, '{8'h22}, 1'b0);
    check(oe_hi == 0, "R2", "no drive on mismatch", oe_hi, 0);
    check(wiper[0] == 8'hFF, "R2", "no load on mismatch", wiper[0], 8'hFF);

    // R8: bits after STOP without START ignored
    oe_hi = 0;
    send_byte({7'h2E, 1'b0}, 0, ak);
    check(!ak && oe_hi == 0, "R8", "no START no ack", ak, 0);
    do_stop();

    // R7: STOP inside a data byte
    do_start();
    send_byte({7'h2E, 1'b0}, 0, ak);
    send_byte(8'h00, 1, ak);
    put_bits(8'h0F, 4, 0);
    do_stop();
    check(wiper[0] == 8'hFF && !sda_oe, "R7", "stop abort", wiper[0], 8'hFF);

    // R7: repeated START inside a data byte, then a full write
    do_start();
    send_byte({7'h2E, 1'b0}, 0, ak);
    send_byte(8'h80, 1, ak);
    put_bits(8'h00, 3, 0);
    check(wiper[1] == 8'h11, "R7", "partial byte no load", wiper[1], 8'h11);
    do_start();
    send_byte({7'h2E, 1'b0}, 0, ak);
    check(ak, "R7", "ack after restart", ak, 1);
    send_byte(8'h80, 1, ak);
    send_byte(8'h77, 2, ak);
    do_stop();
    check(wiper[1] == 8'h77, "R7", "write after restart", wiper[1], 8'h77);

    // R9: strap pins select the low address bits
    pins = 2'b11;
    hold();
    wr(7'h2F, 8'h00, '{8'h44}, 1'b1);
    check(wiper[0] == 8'h44, "R9", "pin address 0101111", wiper[0], 8'h44);
    wr(7'h2E, 8'h00, '{8'h99}, 1'b0);
    check(wiper[0] == 8'h44, "R9", "old address rejected", wiper[0], 8'h44);

    hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule